// File: doc/BRIEF.md
# Circular and Bit-Reversed Address Generator

This block generates addresses for a signal-processing datapath. It holds a working pointer, a lower and an upper buffer bound, and a step size. On each valid request it issues one effective address and, in the same clock edge, updates the pointer according to the requested mode. Five address modes are available:

- plain indirect access
- linear post-increment
- linear pre-decrement
- circular post-increment and circular pre-decrement, which keep the pointer between the two bounds
- bit-reversed access for FFT data shuffling

The four registers are loaded through a small write port. A pointer write takes priority over the mode update when both occur in the same cycle.

In bit-reversed mode, a run-time field selects how many low-order bits of the pointer are mirrored. It is typically changed from one FFT stage to the next. The address bits above that field pass through untouched. The pointer then advances linearly by the step, so a sequence of requests walks through the data in shuffled order.

Top module: `circ_brev_agu`

## Requirements
- R1: After reset, `addr_valid` is 0, `addr_out` is 0, the pointer, lower bound and upper bound are 0, and the step is 1.
- R2: When `wr_en` is 1, `wr_data` is written at the clock edge into the register chosen by `wr_sel`: 0 selects the pointer, 1 the lower bound, 2 the upper bound, 3 the step. A pointer write appears on `ptr_out` after that edge.
- R3: Mode code 0 (indirect), and the unused codes 6 and 7, issue the pointer as the address and leave the pointer unchanged.
- R4: Mode code 1 (post-increment) issues the pointer as the address, then sets the pointer to pointer + step, modulo 2^AW.
- R5: Mode code 2 (pre-decrement) sets the pointer to pointer − step, modulo 2^AW, and issues that new value as the address.
- R6: Mode code 3 (circular increment) issues the pointer as the address. The new pointer is pointer + step. If that sum exceeds the upper bound, the new pointer is lower + (pointer + step − upper − 1), which keeps the offset inside the buffer.
- R7: Mode code 4 (circular decrement) computes pointer − step. If that value lies below the lower bound, it becomes upper − (lower − (pointer − step) − 1). The result is written to the pointer and issued as the address.
- R8: Mode code 5 (bit-reverse) issues the pointer with its low `brev_bits` bits mirrored (bit i takes bit n−1−i). Higher bits are unchanged, and a count of 0 leaves the address equal to the pointer. The pointer then advances by the step.
- R9: `addr_valid` is 1 exactly in the cycle after a cycle with `req_valid` high, with `addr_out` from that request. Without a request, `addr_out` holds and the pointer is unchanged.
- R10: If a pointer write and a request occur in the same cycle, the pointer takes the written value. The address is still formed from the pointer held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 pointer, 1 lower bound, 2 upper bound, 3 step |
| wr_data | input | AW | Write value |
| req_valid | input | 1 | Address request |
| req_mode | input | 3 | Address mode code of the request |
| brev_bits | input | 4 | Number of low bits mirrored in bit-reverse mode |
| addr_valid | output | 1 | Registered address is valid |
| addr_out | output | AW | Registered effective address |
| ptr_out | output | AW | Current pointer value |

## Verification
Circular modes are driven with two step sizes over a 12-entry buffer for enough requests to wrap several times in both directions. This separates a correct offset-preserving wrap from a reset-to-bound wrap or an off-by-one at either bound. Bit-reverse mode is swept over every pointer value below 32 for reversal counts 0 to 5, and a mixed pattern is used for all counts up to 15. This shows whether only the requested bits are mirrored and whether the upper bits pass through. Linear modes are run across the 2^AW boundary in both directions. A pointer write that coincides with a request shows which value wins and which pointer forms the address.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    AM_IND     = 3'd0,
    AM_POSTINC = 3'd1,
    AM_PREDEC  = 3'd2,
    AM_CINC    = 3'd3,
    AM_CDEC    = 3'd4,
    AM_BREV    = 3'd5
  } agu_mode_e;

  typedef enum logic [1:0] {
    RS_PTR   = 2'd0,
    RS_LOWER = 2'd1,
    RS_UPPER = 2'd2,
    RS_STEP  = 2'd3
  } agu_reg_e;
endpackage

// File: rtl/agu_brev.sv
module agu_brev #(
  parameter int AW  = 16,
  parameter int BRW = 4
) (
  input  logic [AW-1:0]  din,
  input  logic [BRW-1:0] nbits,
  output logic [AW-1:0]  dout
);
  int nval;
  always_comb nval = (int'(nbits) > AW) ? AW : int'(nbits);

  for (genvar i = 0; i < AW; i++) begin : g_bit
    logic b;
    always_comb begin
      b = din[i];
      if (i < nval) begin
        for (int k = 0; k < AW; k++) begin
          if (k == nval - 1 - i) b = din[k];
        end
      end
    end
    assign dout[i] = b;
  end
endmodule

// File: rtl/agu_calc.sv
module agu_calc
  import agu_pkg::*;
#(
  parameter int AW  = 16,
  parameter int BRW = 4
) (
  input  logic [2:0]     mode,
  input  logic [BRW-1:0] nbits,
  input  logic [AW-1:0]  ptr,
  input  logic [AW-1:0]  lower,
  input  logic [AW-1:0]  upper,
  input  logic [AW-1:0]  step,
  output logic [AW-1:0]  ea,
  output logic [AW-1:0]  nxt_ptr,
  output logic           moves,
  output logic           wrap_hi,
  output logic           wrap_lo
);
  function automatic logic [AW-1:0] circ_up(input logic [AW-1:0] p, lo, hi, s);
    logic [AW:0] sum, over;
    sum  = {1'b0, p} + {1'b0, s};
    over = sum - {1'b0, hi} - 1'b1;
    return (sum > {1'b0, hi}) ? lo + over[AW-1:0] : sum[AW-1:0];
  endfunction

  function automatic logic [AW-1:0] circ_down(input logic [AW-1:0] p, lo, hi, s);
    logic [AW:0] need, under;
    need  = {1'b0, lo} + {1'b0, s};
    under = need - {1'b0, p} - 1'b1;
    return ({1'b0, p} < need) ? hi - under[AW-1:0] : p - s;
  endfunction

  logic [AW-1:0] rev_addr, inc_lin, dec_lin, inc_circ, dec_circ;

  agu_brev #(.AW(AW), .BRW(BRW)) u_brev (.din(ptr), .nbits(nbits), .dout(rev_addr));

  always_comb begin
    inc_lin  = ptr + step;
    dec_lin  = ptr - step;
    inc_circ = circ_up(ptr, lower, upper, step);
    dec_circ = circ_down(ptr, lower, upper, step);
    wrap_hi  = (mode == AM_CINC) && (({1'b0, ptr} + {1'b0, step}) > {1'b0, upper});
    wrap_lo  = (mode == AM_CDEC) && ({1'b0, ptr} < ({1'b0, lower} + {1'b0, step}));
    ea       = ptr;
    nxt_ptr  = ptr;
    moves    = 1'b1;
    case (mode)
      AM_POSTINC: nxt_ptr = inc_lin;
      AM_PREDEC:  begin nxt_ptr = dec_lin;  ea = dec_lin;  end
      AM_CINC:    nxt_ptr = inc_circ;
      AM_CDEC:    begin nxt_ptr = dec_circ; ea = dec_circ; end
      AM_BREV:    begin nxt_ptr = inc_lin;  ea = rev_addr; end
      default:    moves = 1'b0;
    endcase
  end
endmodule

// File: rtl/agu_regs.sv
module agu_regs
  import agu_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          upd_en,
  input  logic [AW-1:0] upd_ptr,
  output logic [AW-1:0] ptr_q,
  output logic [AW-1:0] lower_q,
  output logic [AW-1:0] upper_q,
  output logic [AW-1:0] step_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      lower_q <= '0;
      upper_q <= '0;
      step_q  <= AW'(1);
    end else begin
      if (wr_en && wr_sel == RS_LOWER) lower_q <= wr_data;
      if (wr_en && wr_sel == RS_UPPER) upper_q <= wr_data;
      if (wr_en && wr_sel == RS_STEP)  step_q  <= wr_data;
      if (wr_en && wr_sel == RS_PTR)   ptr_q   <= wr_data;
      else if (upd_en)                 ptr_q   <= upd_ptr;
    end
  end
endmodule

// File: rtl/circ_brev_agu.sv
module circ_brev_agu
  import agu_pkg::*;
#(
  parameter int AW  = 16,
  parameter int BRW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [1:0]     wr_sel,
  input  logic [AW-1:0]  wr_data,
  input  logic           req_valid,
  input  logic [2:0]     req_mode,
  input  logic [BRW-1:0] brev_bits,
  output logic           addr_valid,
  output logic [AW-1:0]  addr_out,
  output logic [AW-1:0]  ptr_out
);
  logic [AW-1:0] lower_q, upper_q, step_q, ea, nxt_ptr;
  logic          moves, wrap_hi, wrap_lo, ptr_wr_hit, upd_en;

  assign ptr_wr_hit = wr_en && (wr_sel == RS_PTR);
  assign upd_en     = req_valid && moves;

  agu_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .upd_en(upd_en), .upd_ptr(nxt_ptr),
    .ptr_q(ptr_out), .lower_q(lower_q), .upper_q(upper_q), .step_q(step_q)
  );

  agu_calc #(.AW(AW), .BRW(BRW)) u_calc (
    .mode(req_mode), .nbits(brev_bits), .ptr(ptr_out), .lower(lower_q),
    .upper(upper_q), .step(step_q), .ea(ea), .nxt_ptr(nxt_ptr), .moves(moves),
    .wrap_hi(wrap_hi), .wrap_lo(wrap_lo)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_valid <= 1'b0;
      addr_out   <= '0;
    end else begin
      addr_valid <= req_valid;
      if (req_valid) addr_out <= ea;
    end
  end
endmodule

// File: rtl/agu_checker.sv
module agu_checker
  import agu_pkg::*;
#(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [2:0]    req_mode,
  input logic          wr_en,
  input logic [AW-1:0] wr_data,
  input logic          addr_valid,
  input logic [AW-1:0] addr_out,
  input logic [AW-1:0] ptr_out,
  input logic [AW-1:0] lower_q,
  input logic [AW-1:0] upper_q,
  input logic [AW-1:0] step_q,
  input logic          wrap_hi,
  input logic          wrap_lo,
  input logic          ptr_wr_hit
);
  AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> addr_valid); // R9
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !addr_valid && $stable(addr_out)); // R9
  AST_INDIRECT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_mode == AM_IND |=> addr_out == $past(ptr_out)); // R3
  AST_INDIRECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_mode == AM_IND && !wr_en |=> $stable(ptr_out)); // R3
  AST_POSTINC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_mode == AM_POSTINC && !wr_en |=> ptr_out == $past(ptr_out) + $past(step_q)); // R4
  AST_PREDEC_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_mode == AM_PREDEC && !wr_en |=> addr_out == ptr_out); // R5
  AST_WRAP_HI_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && wrap_hi && !wr_en && lower_q <= upper_q |=> ptr_out >= lower_q && ptr_out <= upper_q); // R6
  AST_WRAP_LO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && wrap_lo && !wr_en && lower_q <= upper_q |=> ptr_out >= lower_q && ptr_out <= upper_q); // R7
  AST_PTR_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr_hit |=> ptr_out == $past(wr_data)); // R10
endmodule

bind circ_brev_agu agu_checker #(.AW(AW)) u_chk (.*);

// File: tb/circ_brev_agu_test.sv
module circ_brev_agu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_mode = '0;
  logic [3:0]  brev_bits = '0;
  logic        addr_valid;
  logic [15:0] addr_out, ptr_out;

  int n_checks = 0;
  int n_errs = 0;
  logic [15:0] m_ptr, m_lo, m_hi, m_step;

  always #10 clk = ~clk;

  circ_brev_agu uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .req_valid(req_valid), .req_mode(req_mode), .brev_bits(brev_bits),
    .addr_valid(addr_valid), .addr_out(addr_out), .ptr_out(ptr_out)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rev_model(input logic [15:0] v, input int n);
    logic [15:0] full, mask;
    if (n == 0) return v;
    for (int k = 0; k < 16; k++) full[k] = v[15-k];
    mask = 16'((32'd1 << n) - 1);
    return (v & ~mask) | ((full >> (16 - n)) & mask);
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    case (sel)
      2'd0: m_ptr = d;
      2'd1: m_lo = d;
      2'd2: m_hi = d;
      default: m_step = d;
    endcase
    if (sel == 2'd0) chk("R2 pointer write", ptr_out, d);
  endtask

  task automatic req(input logic [2:0] mode, input int n, input string tag);
    logic [15:0] ea;
    int len, off;
    len = int'(m_hi) - int'(m_lo) + 1;
    off = int'(m_ptr) - int'(m_lo);
    ea = m_ptr;
    case (mode)
      3'd1: m_ptr = m_ptr + m_step;
      3'd2: begin m_ptr = m_ptr - m_step; ea = m_ptr; end
      3'd3: m_ptr = m_lo + 16'((off + int'(m_step)) % len);
      3'd4: begin m_ptr = m_lo + 16'((off - int'(m_step) + len) % len); ea = m_ptr; end
      3'd5: begin ea = rev_model(m_ptr, n); m_ptr = m_ptr + m_step; end
      default: ;
    endcase
    req_valid = 1'b1; req_mode = mode; brev_bits = 4'(n);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, {15'd0, addr_valid}, 16'd1);
    chk({tag, " addr"}, addr_out, ea);
    chk({tag, " ptr"}, ptr_out, m_ptr);
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        n_errs++; n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    m_ptr = 0; m_lo = 0; m_hi = 0; m_step = 1;
    chk("R1 reset valid", {15'd0, addr_valid}, 16'd0);
    chk("R1 reset addr", addr_out, 16'd0);
    chk("R1 reset ptr", ptr_out, 16'd0);
    req(3'd1, 0, "R1 reset step=1 via R4");

    wr(2'd0, 16'h1234);
    req(3'd0, 0, "R3 indirect");
    req(3'd6, 0, "R3 code6");
    req(3'd7, 0, "R3 code7");

    wr(2'd3, 16'd3); wr(2'd0, 16'hFFFD);
    for (int i = 0; i < 4; i++) req(3'd1, 0, "R4 postinc");
    for (int i = 0; i < 4; i++) req(3'd2, 0, "R5 predec");

    wr(2'd1, 16'd8); wr(2'd2, 16'd19); wr(2'd0, 16'd8);
    for (int i = 0; i < 20; i++) req(3'd3, 0, "R6 circinc s3");
    for (int i = 0; i < 20; i++) req(3'd4, 0, "R7 circdec s3");
    wr(2'd3, 16'd5); wr(2'd0, 16'd19);
    for (int i = 0; i < 15; i++) req(3'd3, 0, "R6 circinc s5");
    wr(2'd0, 16'd8);
    for (int i = 0; i < 15; i++) req(3'd4, 0, "R7 circdec s5");
    wr(2'd3, 16'd12); wr(2'd0, 16'd13);
    req(3'd3, 0, "R6 full-length step");
    req(3'd4, 0, "R7 full-length step");

    wr(2'd3, 16'd1);
    for (int n = 0; n <= 5; n++) begin
      wr(2'd0, 16'h0000);
      for (int p = 0; p < 32; p++) req(3'd5, n, "R8 brev sweep");
    end
    for (int n = 0; n <= 15; n++) begin
      wr(2'd0, 16'hA5C3);
      req(3'd5, n, "R8 brev pattern");
    end

    begin
      logic [15:0] last;
      last = addr_out;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        chk("R9 idle valid", {15'd0, addr_valid}, 16'd0);
        chk("R9 idle addr hold", addr_out, last);
        chk("R9 idle ptr hold", ptr_out, m_ptr);
      end
    end

    wr(2'd3, 16'd4); wr(2'd0, 16'h0040);
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 16'h0123;
    req_valid = 1'b1; req_mode = 3'd1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    chk("R10 addr from old ptr", addr_out, 16'h0040);
    chk("R10 write wins", ptr_out, 16'h0123);

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule